// File: doc/BRIEF.md
# Oversampled Serial Receiver with Wakeup Standby

This block receives asynchronous serial characters on a single line. It samples the line at sixteen times the bit rate, using an enable pulse that a baud generator outside the block supplies. A start bit is accepted only when a three-sample majority vote taken around the bit centre confirms it. The data bits arrive least significant first, and the block supports both 8-bit and 9-bit words. Each character ends in a stop bit, which the block checks for a framing error. A received character is held in a data register, and a full flag stays set until the host reads the register.

Software can put the receiver into standby. In standby, incoming characters are dropped and every receive request is masked. A method select decides what ends standby: either a whole character time of idle line, or an address character whose top bit is set. When either event occurs, the hardware clears the standby bit. Receive requests go to one of two outputs, a CPU interrupt line or a DMA request line, and never to both.

Top module: `uart_rx_wake`

## Requirements
- R1: With 8-bit words (`nine_bit`=0), a frame made of a low start bit, eight data bits sent least significant first and a high stop bit loads `rx_data[7:0]` with the byte and clears `rx_data[8]`. It also sets `rx_full` and clears `frame_err`.
- R2: With `nine_bit`=1, nine data bits are received least significant first, and the ninth bit lands in `rx_data[8]`.
- R3: A low pulse on `rxd` that is high again by the 7th to 9th oversample after the falling edge is rejected by the majority vote. No character is received, and `rx_full` stays 0.
- R4: A character whose stop bit samples low is still stored, and `frame_err` is set to 1 for that character.
- R5: A one-cycle `rd_strobe` clears `rx_full` and `idle_flag`.
- R6: Reset clears `rx_en` and `rwu`. While `mod_en`=0, a `cfg_we` strobe leaves both `rx_en` and `rwu` unchanged. While `mod_en`=1, the strobe copies `cfg_rxen` and `cfg_rwu` into them.
- R7: Clearing `rx_en` stops reception. Any `rx_full` and `rx_data` already present are kept, and characters that arrive afterwards are ignored.
- R8: While `rwu`=1, characters that do not end standby are dropped, `rx_full` is never set by them, and `cpu_irq` and `dma_req` are 0.
- R9: With `wake_sel`=0, a stretch of high line lasting 10 bit times (11 in 9-bit mode) while in standby clears `rwu`. The stretch is counted from the standby write or from the last low sample.
- R10: With `wake_sel`=1, a character whose top bit is 1 (bit 7 in 8-bit mode, bit 8 in 9-bit mode) clears `rwu` and is stored. Idle line and characters whose top bit is 0 leave `rwu` at 1.
- R11: Outside standby, a full character time of idle line that follows a stored character sets `idle_flag` once. The flag does not set again until another character has been stored.
- R12: `cpu_irq` equals `!rwu & !dma_en & (rx_full | (ilie & idle_flag))`, and `dma_req` equals `!rwu & dma_en & rx_full`. Each is registered and follows its inputs one clock later. With `dma_en`=1, `ilie` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Oversample enable, 16 per bit time |
| rxd | input | 1 | Serial data line, idle high |
| mod_en | input | 1 | Module enable; gates configuration writes and reception |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_rxen | input | 1 | Receiver enable value written by `cfg_we` |
| cfg_rwu | input | 1 | Standby value written by `cfg_we` |
| wake_sel | input | 1 | 0: idle line ends standby, 1: address character ends standby |
| nine_bit | input | 1 | 1 selects 9-bit words |
| ilie | input | 1 | Idle-line interrupt enable |
| dma_en | input | 1 | Route receive requests to DMA instead of CPU |
| rd_strobe | input | 1 | Data register read; clears status flags |
| rx_data | output | 9 | Last stored character |
| rx_full | output | 1 | Data register holds an unread character |
| idle_flag | output | 1 | Idle line seen after a character |
| frame_err | output | 1 | Stop bit of the stored character sampled low |
| rx_en | output | 1 | Receiver enable state |
| rwu | output | 1 | Standby state |
| cpu_irq | output | 1 | CPU receive interrupt request |
| dma_req | output | 1 | DMA receive request |

## Verification
The assertions assume that `tick16` arrives at a steady rate of at most one pulse every other clock. They also assume that `wake_sel`, `nine_bit` and `dma_en` change only while the line is idle, so that a request computed one cycle earlier still matches the routing that is checked. The stimulus runs `tick16` at one pulse every four clocks and changes mode inputs only between frames. It drives every frame bit for exactly sixteen ticks and spaces glitches far enough apart that the vote window sees a clean level.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic [8:0] word;
    logic       ferr;
  } rx_char_t;
endpackage

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     tick,
  input  logic     rxd_s,
  input  logic     run,
  input  logic     nine,
  output logic     char_vld,
  output rx_char_t char_o
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] VOTE_LO = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] VOTE_HI = CW'(OSR / 2 + 1);
  localparam logic [CW-1:0] LAST    = CW'(OSR - 1);

  rx_state_e     st;
  logic [CW-1:0] cnt;
  logic [1:0]    votes;
  logic [3:0]    bitn;
  logic [8:0]    shreg;
  logic          maj;
  logic [3:0]    last_bit;

  assign maj      = (votes[1] & votes[0]) | (votes[1] & rxd_s) | (votes[0] & rxd_s);
  assign last_bit = nine ? 4'd8 : 4'd7;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      votes    <= 2'b11;
      bitn     <= '0;
      shreg    <= '0;
      char_vld <= 1'b0;
      char_o   <= '0;
    end else begin
      char_vld <= 1'b0;
      if (tick) begin
        if (st == ST_IDLE) begin
          if (!rxd_s) begin
            st    <= ST_START;
            cnt   <= CW'(1);
            shreg <= '0;
            bitn  <= '0;
          end
        end else begin
          cnt <= (cnt == LAST) ? '0 : cnt + CW'(1);
          if (cnt >= VOTE_LO && cnt < VOTE_HI)
            votes <= {votes[0], rxd_s};
          unique case (st)
            ST_START: begin
              if (cnt == VOTE_HI && maj) st <= ST_IDLE;
              else if (cnt == LAST)      st <= ST_DATA;
            end
            ST_DATA: begin
              if (cnt == VOTE_HI) shreg[bitn] <= maj;
              if (cnt == LAST) begin
                if (bitn == last_bit) st <= ST_STOP;
                else bitn <= bitn + 4'd1;
              end
            end
            ST_STOP: begin
              if (cnt == VOTE_HI) begin
                char_vld    <= 1'b1;
                char_o.word <= shreg;
                char_o.ferr <= !maj;
                st          <= ST_IDLE;
              end
            end
            default: st <= ST_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/uart_rx_idle.sv
module uart_rx_idle #(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic rxd_s,
  input  logic run,
  input  logic nine,
  input  logic restart,
  output logic idle_hit
);
  localparam int LIM8 = 10 * OSR;
  localparam int LIM9 = 11 * OSR;
  localparam int IW   = $clog2(LIM9 + 1);

  logic [IW-1:0] cnt;
  logic [IW-1:0] limit;

  assign limit = nine ? IW'(LIM9) : IW'(LIM8);

  always_ff @(posedge clk) begin
    if (rst || !run || restart) begin
      cnt      <= '0;
      idle_hit <= 1'b0;
    end else begin
      idle_hit <= 1'b0;
      if (tick) begin
        if (!rxd_s) begin
          cnt <= '0;
        end else if (cnt < limit) begin
          cnt <= cnt + IW'(1);
          if (cnt == limit - IW'(1)) idle_hit <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/uart_rx_ctl.sv
module uart_rx_ctl
  import uart_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       mod_en,
  input  logic       cfg_we,
  input  logic       cfg_rxen,
  input  logic       cfg_rwu,
  input  logic       wake_sel,
  input  logic       nine,
  input  logic       ilie,
  input  logic       dma_en,
  input  logic       rd,
  input  logic       char_vld,
  input  rx_char_t   char_i,
  input  logic       idle_hit,
  output logic       rx_en_q,
  output logic       rwu_q,
  output logic [8:0] data_q,
  output logic       full_q,
  output logic       idle_q,
  output logic       ferr_q,
  output logic       cpu_irq,
  output logic       dma_req,
  output logic       restart
);
  logic wr_ok, msb, wake_addr, wake_idle, store, armed;

  assign wr_ok     = cfg_we && mod_en;
  assign restart   = wr_ok && cfg_rwu;
  assign msb       = nine ? char_i.word[8] : char_i.word[7];
  assign wake_addr = rwu_q && wake_sel && char_vld && msb;
  assign wake_idle = rwu_q && !wake_sel && idle_hit;
  assign store     = char_vld && (!rwu_q || wake_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_en_q <= 1'b0;
      rwu_q   <= 1'b0;
      data_q  <= '0;
      full_q  <= 1'b0;
      idle_q  <= 1'b0;
      ferr_q  <= 1'b0;
      armed   <= 1'b0;
      cpu_irq <= 1'b0;
      dma_req <= 1'b0;
    end else begin
      if (wr_ok) begin
        rx_en_q <= cfg_rxen;
        rwu_q   <= cfg_rwu;
      end else if (wake_addr || wake_idle) begin
        rwu_q <= 1'b0;
      end

      if (store) begin
        data_q <= char_i.word;
        ferr_q <= char_i.ferr;
        full_q <= 1'b1;
        armed  <= 1'b1;
      end else if (rd) begin
        full_q <= 1'b0;
      end

      if (idle_hit && !rwu_q && armed && !store) begin
        idle_q <= 1'b1;
        armed  <= 1'b0;
      end else if (rd) begin
        idle_q <= 1'b0;
      end

      cpu_irq <= !rwu_q && !dma_en && (full_q || (ilie && idle_q));
      dma_req <= !rwu_q && dma_en && full_q;
    end
  end
endmodule

// File: rtl/uart_rx_wake.sv
module uart_rx_wake
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick16,
  input  logic       rxd,
  input  logic       mod_en,
  input  logic       cfg_we,
  input  logic       cfg_rxen,
  input  logic       cfg_rwu,
  input  logic       wake_sel,
  input  logic       nine_bit,
  input  logic       ilie,
  input  logic       dma_en,
  input  logic       rd_strobe,
  output logic [8:0] rx_data,
  output logic       rx_full,
  output logic       idle_flag,
  output logic       frame_err,
  output logic       rx_en,
  output logic       rwu,
  output logic       cpu_irq,
  output logic       dma_req
);
  logic     rx_m, rx_s;
  logic     run, char_vld, idle_hit, restart;
  rx_char_t char_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
    end else begin
      rx_m <= rxd;
      rx_s <= rx_m;
    end
  end

  assign run = mod_en && rx_en;

  uart_rx_frame #(.OSR(OSR)) u_frame (
    .clk(clk), .rst(rst), .tick(tick16), .rxd_s(rx_s), .run(run),
    .nine(nine_bit), .char_vld(char_vld), .char_o(char_w)
  );

  uart_rx_idle #(.OSR(OSR)) u_idle (
    .clk(clk), .rst(rst), .tick(tick16), .rxd_s(rx_s), .run(run),
    .nine(nine_bit), .restart(restart), .idle_hit(idle_hit)
  );

  uart_rx_ctl u_ctl (
    .clk(clk), .rst(rst), .mod_en(mod_en), .cfg_we(cfg_we),
    .cfg_rxen(cfg_rxen), .cfg_rwu(cfg_rwu), .wake_sel(wake_sel),
    .nine(nine_bit), .ilie(ilie), .dma_en(dma_en), .rd(rd_strobe),
    .char_vld(char_vld), .char_i(char_w), .idle_hit(idle_hit),
    .rx_en_q(rx_en), .rwu_q(rwu), .data_q(rx_data), .full_q(rx_full),
    .idle_q(idle_flag), .ferr_q(frame_err), .cpu_irq(cpu_irq),
    .dma_req(dma_req), .restart(restart)
  );
endmodule

// File: rtl/uart_rx_wake_chk.sv
module uart_rx_wake_chk (
  input logic       clk,
  input logic       rst,
  input logic       mod_en,
  input logic       cfg_we,
  input logic       wake_sel,
  input logic       dma_en,
  input logic       rx_full,
  input logic       rx_en,
  input logic       rwu,
  input logic       cpu_irq,
  input logic       dma_req
);
  // R12
  req_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(cpu_irq && dma_req));

  // R12
  dma_mutes_cpu_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_irq |-> !$past(dma_en));

  // R8
  standby_mask_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rwu) |-> (!cpu_irq && !dma_req));

  // R8
  full_outside_standby_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(rx_full) && !$past(cfg_we)) |-> !rwu);

  // R6
  write_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    !mod_en |=> ($stable(rx_en) && $stable(rwu)));

  // R10
  addr_wake_stores_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(rwu) && !$past(cfg_we) && $past(wake_sel)) |-> rx_full);
endmodule

bind uart_rx_wake uart_rx_wake_chk u_chk (
  .clk(clk), .rst(rst), .mod_en(mod_en), .cfg_we(cfg_we),
  .wake_sel(wake_sel), .dma_en(dma_en), .rx_full(rx_full), .rx_en(rx_en),
  .rwu(rwu), .cpu_irq(cpu_irq), .dma_req(dma_req)
);

// File: tb/uart_rx_wake_test.sv
`timescale 1ns/1ps
module uart_rx_wake_test;
  localparam int BITCLK = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick16 = 1'b0;
  logic rxd = 1'b1;
  logic mod_en = 1'b0, cfg_we = 1'b0, cfg_rxen = 1'b0, cfg_rwu = 1'b0;
  logic wake_sel = 1'b0, nine_bit = 1'b0, ilie = 1'b0, dma_en = 1'b0, rd_strobe = 1'b0;
  logic [8:0] rx_data;
  logic rx_full, idle_flag, frame_err, rx_en, rwu, cpu_irq, dma_req;
  logic [1:0] tdiv = '0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  always @(negedge clk) begin
    tdiv   <= tdiv + 2'd1;
    tick16 <= (tdiv == 2'd3);
  end

  uart_rx_wake uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_req(input logic full, input logic idl,
                                         input logic ie, input logic dm, input logic sb);
    return {!sb && !dm && (full || (ie && idl)), !sb && dm && full};
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input logic re, input logic wu);
    @(negedge clk);
    cfg_rxen = re; cfg_rwu = wu; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    wait_clk(2);
  endtask

  task automatic rd();
    @(negedge clk);
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    wait_clk(2);
  endtask

  task automatic send(input logic [8:0] w, input int nb, input logic stopv);
    @(negedge clk);
    rxd = 1'b0;
    wait_clk(BITCLK);
    for (int i = 0; i < nb; i++) begin
      rxd = w[i];
      wait_clk(BITCLK);
    end
    rxd = stopv;
    wait_clk(BITCLK);
    rxd = 1'b1;
    wait_clk(8);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    logic [1:0] r;
    void'($urandom(32'd4242));
    wait_clk(6);
    rst = 1'b0;
    wait_clk(2);
    // R6 reset state
    chk("R6 reset rx_en", rx_en, 0);
    chk("R6 reset rwu", rwu, 0);
    chk("R6 reset full", rx_full, 0);
    chk("R12 reset req", {cpu_irq, dma_req}, 0);

    // R6 writes ignored with module disabled
    cfg(1'b1, 1'b1);
    chk("R6 blocked rx_en", rx_en, 0);
    chk("R6 blocked rwu", rwu, 0);
    mod_en = 1'b1;
    cfg(1'b1, 1'b0);
    chk("R6 write rx_en", rx_en, 1);

    // R1 directed
    send(9'h0A5, 8, 1'b1);
    chk("R1 data", rx_data, 9'h0A5);
    chk("R1 full", rx_full, 1);
    chk("R1 ferr", frame_err, 0);
    chk("R12 cpu req", {cpu_irq, dma_req}, 2'b10);
    rd();
    chk("R5 read clears full", rx_full, 0);

    // R1 R12 random bytes with random routing
    for (int k = 0; k < 16; k++) begin
      b = 8'($urandom);
      r = 2'($urandom);
      ilie = r[0]; dma_en = r[1];
      send({1'b0, b}, 8, 1'b1);
      chk("R1 rand data", rx_data, {1'b0, b});
      chk("R1 rand full", rx_full, 1);
      chk("R12 rand req", {cpu_irq, dma_req}, exp_req(rx_full, idle_flag, ilie, dma_en, rwu));
      rd();
      chk("R5 rand clear", rx_full, 0);
    end
    ilie = 1'b0; dma_en = 1'b0;

    // R2 nine-bit word
    nine_bit = 1'b1;
    send(9'h1C3, 9, 1'b1);
    chk("R2 data", rx_data, 9'h1C3);
    rd();
    nine_bit = 1'b0;

    // R11 idle flag after a character
    send(9'h03C, 8, 1'b1);
    chk("R11 not yet idle", idle_flag, 0);
    wait_clk(12 * BITCLK);
    chk("R11 idle set", idle_flag, 1);
    ilie = 1'b1;
    dma_en = 1'b1;
    wait_clk(3);
    chk("R12 dma masks cpu", {cpu_irq, dma_req}, 2'b01);
    dma_en = 1'b0;
    rd();
    chk("R5 idle cleared", idle_flag, 0);
    wait_clk(3);
    chk("R12 no req after read", {cpu_irq, dma_req}, 2'b00);
    wait_clk(12 * BITCLK);
    chk("R11 once per idle", idle_flag, 0);
    ilie = 1'b0;

    // R3 short low glitch rejected
    @(negedge clk);
    rxd = 1'b0;
    wait_clk(12);
    rxd = 1'b1;
    wait_clk(11 * BITCLK);
    chk("R3 glitch rejected", rx_full, 0);

    // R4 framing error
    send(9'h066, 8, 1'b0);
    chk("R4 data kept", rx_data, 9'h066);
    chk("R4 ferr", frame_err, 1);
    wait_clk(2 * BITCLK);
    rd();
    send(9'h011, 8, 1'b1);
    chk("R4 ferr cleared", frame_err, 0);
    rd();

    // R10 address-mark wake
    wake_sel = 1'b1;
    cfg(1'b1, 1'b1);
    chk("R8 standby entered", rwu, 1);
    send(9'h012, 8, 1'b1);
    chk("R8 dropped full", rx_full, 0);
    chk("R8 no req", {cpu_irq, dma_req}, 0);
    wait_clk(12 * BITCLK);
    chk("R10 idle no wake", rwu, 1);
    send(9'h085, 8, 1'b1);
    chk("R10 woke", rwu, 0);
    chk("R10 stored", rx_data, 9'h085);
    chk("R10 full", rx_full, 1);
    rd();

    // R9 idle-line wake
    wake_sel = 1'b0;
    cfg(1'b1, 1'b1);
    send(9'h033, 8, 1'b1);
    chk("R9 still standby", rwu, 1);
    chk("R8 dropped idle mode", rx_full, 0);
    wait_clk(12 * BITCLK);
    chk("R9 woke", rwu, 0);
    send(9'h044, 8, 1'b1);
    chk("R9 stored after wake", rx_data, 9'h044);
    rd();

    // R7 disabling keeps flags
    send(9'h05A, 8, 1'b1);
    cfg(1'b0, 1'b0);
    chk("R7 rx_en off", rx_en, 0);
    chk("R7 full kept", rx_full, 1);
    send(9'h011, 8, 1'b1);
    chk("R7 data kept", rx_data, 9'h05A);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule